// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This block keeps the interrupt status byte of a USB host port. Two transfer engines report completion, a start-of-frame timer reports each expiry, and a decoded bus line state arrives on a two-bit input. The unit latches each event into its own status bit. It also watches the line state for a device being attached or detached. Bit 6 is shared: a mode input selects whether it shows live device absence or a latched resume-detect interrupt. Software clears latched bits by writing ones to them. A single interrupt line is raised while any latched bit that the enable mask selects is set.

The line state is sampled only on a 12 MHz tick enable. A new line level takes effect only after it has held for a parameterised number of consecutive ticks, so short glitches on the cable do not cause false attach or detach events. The reset input is asynchronous and active low. It is released synchronously through a two-flop stage inside the block.

Top module: `usb_hint_status`

## Requirements
- R1: A pulse on `xfer_a_done` sets status bit 0 and a pulse on `xfer_b_done` sets status bit 1, one clock later.
- R2: Status bits 2, 3 and 7 always read as 0.
- R3: A pulse on `sof_expire` sets status bit 4 one clock later.
- R4: Line-state encoding on `line_st`: 00 = SE0, 01 = IDLE, 10 = K, 11 = SE1. Bit 5 is set when the filtered line state moves from SE0 to IDLE or from IDLE to SE0. The state is updated and bit 5 is set on the clock edge at which the confirming tick is sampled.
- R5: A new line level is accepted only after `STABLE_TICKS` consecutive `tick_12m` samples of that level. Shorter excursions, K, SE1, and line changes with no tick have no effect on bits 5 and 6.
- R6: With `resume_mode` = 1, bit 6 reads a latched resume interrupt that `resume_det` sets. A `resume_det` pulse while `resume_mode` = 0 is ignored.
- R7: With `resume_mode` = 0, bit 6 reads live device absence: 1 when the filtered line state is SE0 (no device) and 0 after IDLE has been accepted (device present).
- R8: A write with `clr_we` = 1 clears every latched bit whose position in `clr_data` is 1. An event arriving in the same cycle wins, and the bit stays set.
- R9: `irq` is the OR over the latched bits (0, 1, 4, 5, and bit 6 only while `resume_mode` = 1) ANDed bitwise with `irq_mask`. Live absence never drives `irq`.
- R10: In reset, `status` reads 0x40 (no device, nothing latched) and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_12m | input | 1 | One-cycle enable at the 12 MHz bit rate |
| line_st | input | 2 | Decoded bus line state (00 SE0, 01 IDLE, 10 K, 11 SE1) |
| xfer_a_done | input | 1 | Transfer engine A done pulse |
| xfer_b_done | input | 1 | Transfer engine B done pulse |
| sof_expire | input | 1 | Start-of-frame timer expiry pulse |
| resume_det | input | 1 | Resume detected pulse |
| resume_mode | input | 1 | Selects bit 6 meaning: 1 resume interrupt, 0 device absence |
| clr_we | input | 1 | Write strobe for the clear mask |
| clr_data | input | 8 | Write-one-to-clear mask |
| irq_mask | input | 8 | Per-bit interrupt enable |
| status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `STABLE_TICKS` = 3 instead of the default 2. With this value it can show that two matching ticks still leave the attach state unchanged, and that the third tick commits it. A two-tick excursion to SE0 from the attached state then returns to IDLE. This exercises a glitch that is long enough to refill the counter but still too short to be accepted. The same build drives the K state for a full filter window to confirm that only SE0 and IDLE transitions count.

// File: rtl/hint_pkg.sv
package hint_pkg;
  localparam int STAT_W = 8;

  localparam logic [1:0] LS_SE0  = 2'b00;
  localparam logic [1:0] LS_IDLE = 2'b01;
  localparam logic [1:0] LS_K    = 2'b10;
  localparam logic [1:0] LS_SE1  = 2'b11;

  localparam int B_XA   = 0;
  localparam int B_XB   = 1;
  localparam int B_SOF  = 4;
  localparam int B_CONN = 5;
  localparam int B_SHR  = 6;

  // bits that own a latch; the rest are tied to zero
  localparam logic [STAT_W-1:0] LATCH_MAP = 8'b0111_0011;
endpackage

// File: rtl/hint_rst_sync.sv
module hint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hint_line_filter.sv
module hint_line_filter
  import hint_pkg::*;
#(
  parameter int STABLE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] line_st,
  output logic       absent,
  output logic       conn_evt
);
  localparam int CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] LIM    = CW'(STABLE_TICKS);
  localparam logic [CW-1:0] LIM_M1 = CW'(STABLE_TICKS - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [1:0]    cand_q, cand_d;
  logic [1:0]    acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          commit;
  logic          cand_ok;

  assign cand_ok = (cand_q == LS_SE0) || (cand_q == LS_IDLE);

  always_comb begin
    cand_d = cand_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    commit = 1'b0;
    if (tick) begin
      if (line_st != cand_q) begin
        cand_d = line_st;
        cnt_d  = ONE;
      end else begin
        if (cnt_q < LIM) cnt_d = cnt_q + ONE;
        if ((cnt_q >= LIM_M1) && cand_ok && (cand_q != acc_q)) begin
          commit = 1'b1;
          acc_d  = cand_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= LS_SE0;
      cnt_q  <= '0;
      acc_q  <= LS_SE0;
    end else if (tick) begin
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
    end
  end

  assign absent   = (acc_q == LS_SE0);
  assign conn_evt = commit;
endmodule

// File: rtl/hint_evt_latch.sv
module hint_evt_latch #(
  parameter int               W   = 8,
  parameter logic [W-1:0]     MAP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MAP[i]) begin : g_lat
      logic bit_q, bit_d;
      always_comb begin
        bit_d = bit_q;
        if (clr[i]) bit_d = 1'b0;
        if (set[i]) bit_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign q[i] = bit_q;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_hint_status.sv
module usb_hint_status
  import hint_pkg::*;
#(
  parameter int STABLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_12m,
  input  logic [1:0]        line_st,
  input  logic              xfer_a_done,
  input  logic              xfer_b_done,
  input  logic              sof_expire,
  input  logic              resume_det,
  input  logic              resume_mode,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic              rst_sync_n;
  logic              absent;
  logic              conn_evt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] lat;
  logic [STAT_W-1:0] irq_src;

  hint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hint_line_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_12m),
    .line_st  (line_st),
    .absent   (absent),
    .conn_evt (conn_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_XA]   = xfer_a_done;
    set_vec[B_XB]   = xfer_b_done;
    set_vec[B_SOF]  = sof_expire;
    set_vec[B_CONN] = conn_evt;
    set_vec[B_SHR]  = resume_det & resume_mode;
    clr_vec         = clr_we ? clr_data : '0;
  end

  hint_evt_latch #(.W(STAT_W), .MAP(LATCH_MAP)) u_lat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (set_vec),
    .clr   (clr_vec),
    .q     (lat)
  );

  always_comb begin
    status        = lat;
    status[B_SHR] = resume_mode ? lat[B_SHR] : absent;
    irq_src       = lat;
    irq_src[B_SHR] = lat[B_SHR] & resume_mode;
  end

  assign irq = |(irq_src & irq_mask);
endmodule

// File: rtl/usb_hint_status_chk.sv
module usb_hint_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_12m,
  input logic       xfer_a_done,
  input logic       xfer_b_done,
  input logic       sof_expire,
  input logic       clr_we,
  input logic [7:0] clr_data,
  input logic [7:0] irq_mask,
  input logic [7:0] status,
  input logic       irq
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == 1'b0) && (status[3:2] == 2'b00));

  a_r1_a_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_a_done |=> status[0]);

  a_r1_b_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_b_done |=> status[1]);

  a_r3_sof_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sof_expire |=> status[4]);

  a_r8_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(clr_we && clr_data[0])) |=> status[0]);

  a_r5_conn_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_12m |=> !$rose(status[5]));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 8'h00) |-> !irq);
endmodule

bind usb_hint_status usb_hint_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_12m    (tick_12m),
  .xfer_a_done (xfer_a_done),
  .xfer_b_done (xfer_b_done),
  .sof_expire  (sof_expire),
  .clr_we      (clr_we),
  .clr_data    (clr_data),
  .irq_mask    (irq_mask),
  .status      (status),
  .irq         (irq)
);

// File: tb/usb_hint_status_tb_top.sv
module usb_hint_status_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tick_12m;
  logic [1:0] line_st;
  logic       xa, xb, sof, res, mode, cwe;
  logic [7:0] cdat, mask;
  logic [7:0] status;
  logic       irq;

  int n_run;
  int n_fail;
  bit done;

  usb_hint_status #(.STABLE_TICKS(3)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_12m    (tick_12m),
    .line_st     (line_st),
    .xfer_a_done (xa),
    .xfer_b_done (xb),
    .sof_expire  (sof),
    .resume_det  (res),
    .resume_mode (mode),
    .clr_we      (cwe),
    .clr_data    (cdat),
    .irq_mask    (mask),
    .status      (status),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {a, b, sof, res, mode, clr_we, clr[7:0], mask[7:0], exp_status[7:0], exp_irq}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,8'h41,1'b0}, // R1 A
    {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h01,8'h43,1'b1}, // R1 B, R9
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h01,8'h01,8'h42,1'b0}, // R8 clear
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h02,8'h10,8'h50,1'b1}, // R3 SOF
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h10,8'h10,8'h50,1'b1}, // R8 priority
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hFF,8'hFF,8'h40,1'b0}, // R9 live bit no irq
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'hFF,8'h40,1'b0}, // R6 ignored
    {1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h40,8'h40,1'b1}, // R6 latched
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h40,8'h40,8'h00,1'b0}, // R6 R8 clear
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h40,8'h40,1'b0}  // R7 absent
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick_once();
    tick_12m = 1'b1;
    @(negedge clk);
    tick_12m = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    tick_12m = 0; line_st = 2'b00; xa = 0; xb = 0; sof = 0; res = 0;
    mode = 0; cwe = 0; cdat = 8'h00; mask = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check8("R10 reset status", status, 8'h40);
    check1("R10 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check8("R10 after release", status, 8'h40);

    for (int i = 0; i < NV; i++) begin
      {xa, xb, sof, res, mode, cwe, cdat, mask} = VEC[i][30:9];
      @(negedge clk);
      check8($sformatf("R1-R9 vector %0d status", i), status, VEC[i][8:1]);
      check1($sformatf("R9 vector %0d irq", i), irq, VEC[i][0]);
      check1("R2 reserved bits", |{status[7], status[3:2]}, 1'b0);
    end
    {xa, xb, sof, res, mode, cwe, cdat} = '0;
    mask = 8'h20;

    // R5: line change with no tick does nothing
    line_st = 2'b01;
    repeat (5) @(negedge clk);
    check8("R5 no tick no change", status, 8'h40);
    // R5: two ticks are not enough with STABLE_TICKS = 3
    tick_once(); tick_once();
    check8("R5 two ticks short", status, 8'h40);
    // R4 insertion on third tick
    tick_once();
    check8("R4 insert status", status, 8'h20);
    check1("R9 insert irq", irq, 1'b1);
    cwe = 1; cdat = 8'h20; @(negedge clk); cwe = 0; cdat = 8'h00;
    check8("R8 clear conn", status, 8'h00);

    // R5 glitch: two ticks of SE0 then back to IDLE
    line_st = 2'b00; tick_once(); tick_once();
    line_st = 2'b01; tick_once(); tick_once(); tick_once();
    check8("R5 glitch ignored", status, 8'h00);

    // R4 removal
    line_st = 2'b00; tick_once(); tick_once(); tick_once();
    check8("R4 remove status", status, 8'h60);
    cwe = 1; cdat = 8'h20; @(negedge clk); cwe = 0; cdat = 8'h00;
    check8("R7 absent after clear", status, 8'h40);

    // R5: K held a full window is not an attach
    line_st = 2'b10; tick_once(); tick_once(); tick_once(); tick_once();
    check8("R5 K ignored", status, 8'h40);
    check1("R9 K irq", irq, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule